// File: doc/BRIEF.md
# Word-Addressed Transfer Buffer

A 128-word by 32-bit staging buffer that sits between a host register port and a serial transfer engine. The host sees two registers. One is a control register that holds the transfer direction, an auto-increment enable and a word pointer. The other is a data window that reads or writes the word the pointer selects. When auto-increment is on, every window access that takes effect moves the pointer to the next word. The direction bit decides which access takes effect. In fill mode the host writes into the window. In drain mode the host reads from it.

The engine side works in bytes. The engine pulses a start strobe with a word address, which loads a 9-bit byte index and moves the sequencer from `SEQ_IDLE` to `SEQ_ACTIVE`. Each byte strobe then reads or writes one byte and steps the index. Byte order is little-endian: byte 0 of a word is lane 0, bits 7:0. This means a transfer whose length is not a multiple of four leaves its last bytes in the low lanes. While the sequencer is active, the engine owns the buffer. In the cycle the engine starts, it also wins against the host. Host accesses made in either case are dropped, and host reads return zero.

Sequencer transitions:
- `SEQ_IDLE` goes to `SEQ_ACTIVE` on a start pulse.
- `SEQ_ACTIVE` stays in `SEQ_ACTIVE` on a start pulse, which restarts the transfer.
- `SEQ_ACTIVE` returns to `SEQ_IDLE` on a done pulse that has no start pulse beside it.

Top module: `tbuf_xfer_buffer`

## Requirements
- R1: After reset, the control register reads zero, `eng_busy` is low, and every buffer word reads zero.
- R2: The control register is at `host_addr`=0 and the data window is at `host_addr`=1. In the control register, bit 31 is direction (1 = fill, 0 = drain), bit 30 is auto-increment, and bits 6:0 are the word pointer. Bits 29:7 read zero, and pointer bit 7 is dropped on a write. `host_rdata` is updated at the clock edge that samples `host_rd` and then holds.
- R3: In fill mode a window write stores the whole word at the pointer. In drain mode a window read returns the word at the pointer. A window access against the direction stores nothing, returns zero and leaves the pointer unchanged.
- R4: With auto-increment set, each window access that takes effect advances the pointer by one. With it clear, the pointer stays where it is.
- R5: The word pointer wraps from 127 to 0.
- R6: The sequencer moves from `SEQ_IDLE` to `SEQ_ACTIVE` on `eng_start` and returns to `SEQ_IDLE` on `eng_done` when no start is present. A start while active restarts the transfer. `eng_busy` is high exactly in `SEQ_ACTIVE`.
- R7: A start loads the byte index with start word × 4. Each accepted byte strobe (read or write, while active, no start that cycle) advances the index by one, and the index wraps from 511 to 0. Byte strobes while idle are ignored.
- R8: Byte index i maps to word i/4, lane i mod 4, bits 8·lane+7 down to 8·lane. `eng_rdata` shows the byte at the current index without delay.
- R9: An engine byte write changes only its own lane. After a partial final word, the untouched upper lanes keep their earlier contents.
- R10: A host access made while `eng_busy` is high, or in the same cycle as `eng_start`, changes no buffer word, control field or pointer, and a host read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 1 | 0 = control register, 1 = data window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| eng_start | input | 1 | Engine start pulse |
| eng_start_word | input | 7 | Start word address |
| eng_done | input | 1 | Engine end-of-transfer pulse |
| eng_byte_wr | input | 1 | Engine byte write strobe |
| eng_byte_rd | input | 1 | Engine byte read (consume) strobe |
| eng_wdata | input | 8 | Engine write byte |
| eng_rdata | output | 8 | Byte at the current index |
| eng_busy | output | 1 | Sequencer active |

## Verification
The hardest cases to reach from the ports are a host access in exactly the cycle of an engine start, and the two wrap points: the word pointer going from 127 to 0, and the byte index going from 511 to 0.

The bench reaches the first by driving `eng_start` and a window write on the same falling edge. It reaches the wraps by programming the pointer to 127 and by starting the engine at word 127 and stepping five bytes.

Random rounds fill the buffer from one side and drain it from the other, with random start words and odd byte counts. This exercises partial final words and transfers that cross the wrap.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

    localparam int BYTE_W      = 8;
    localparam int PTR_FIELD_W = 8;

    localparam logic HOST_REG_CTRL = 1'b0;
    localparam logic HOST_REG_DATA = 1'b1;

    typedef enum logic [0:0] {
        SEQ_IDLE   = 1'b0,
        SEQ_ACTIVE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic fill;
        logic auto_inc;
    } host_mode_t;

endpackage

// File: rtl/tbuf_store.sv
module tbuf_store #(
    parameter int WORDS  = 128,
    parameter int DATA_W = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      host_we,
    input  logic [$clog2(WORDS)-1:0]                  host_waddr,
    input  logic [DATA_W-1:0]                         host_wdata,
    output logic [DATA_W-1:0]                         host_rword,
    input  logic                                      eng_we,
    input  logic [$clog2(WORDS)+$clog2(DATA_W/8)-1:0] eng_idx,
    input  logic [tbuf_pkg::BYTE_W-1:0]               eng_wbyte,
    output logic [tbuf_pkg::BYTE_W-1:0]               eng_rbyte
);
    localparam int BW      = tbuf_pkg::BYTE_W;
    localparam int LANES   = DATA_W / BW;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WADDR_W = $clog2(WORDS);

    logic [DATA_W-1:0]  mem_q [WORDS];
    logic [WADDR_W-1:0] eng_word;
    logic [LANE_W-1:0]  eng_lane;
    logic [DATA_W-1:0]  eng_word_data;

    assign eng_word      = eng_idx[WADDR_W+LANE_W-1:LANE_W];
    assign eng_lane      = eng_idx[LANE_W-1:0];
    assign eng_word_data = mem_q[eng_word];
    assign host_rword    = mem_q[host_waddr];

    // lane select for the engine read byte
    always_comb begin
        eng_rbyte = '0;
        for (int l = 0; l < LANES; l++) begin
            if (eng_lane == LANE_W'(l)) begin
                eng_rbyte = eng_word_data[l*BW +: BW];
            end
        end
    end

    // engine byte write has priority over a host word write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else if (eng_we) begin
            for (int l = 0; l < LANES; l++) begin
                if (eng_lane == LANE_W'(l)) begin
                    mem_q[eng_word][l*BW +: BW] <= eng_wbyte;
                end
            end
        end else if (host_we) begin
            mem_q[host_waddr] <= host_wdata;
        end
    end

endmodule

// File: rtl/tbuf_seq.sv
module tbuf_seq #(
    parameter int WORDS = 128,
    parameter int LANES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   eng_start,
    input  logic [$clog2(WORDS)-1:0]               start_word,
    input  logic                                   eng_done,
    input  logic                                   byte_rd,
    input  logic                                   byte_wr,
    output logic                                   busy,
    output logic                                   wr_go,
    output logic [$clog2(WORDS)+$clog2(LANES)-1:0] byte_idx
);
    import tbuf_pkg::*;

    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = $clog2(WORDS) + LANE_W;

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             step;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (eng_start) state_d = SEQ_ACTIVE;
            end
            SEQ_ACTIVE: begin
                if (eng_start)     state_d = SEQ_ACTIVE;
                else if (eng_done) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy  = 1'b0;
        step  = 1'b0;
        wr_go = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                busy = 1'b0;
            end
            SEQ_ACTIVE: begin
                busy  = 1'b1;
                step  = !eng_start && (byte_rd || byte_wr);
                wr_go = !eng_start && byte_wr;
            end
            default: busy = 1'b0;
        endcase
    end

    // byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (eng_start) begin
            idx_q <= {start_word, {LANE_W{1'b0}}};
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign byte_idx = idx_q;

endmodule

// File: rtl/tbuf_host_port.sv
module tbuf_host_port #(
    parameter int WORDS  = 128,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_addr,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [DATA_W-1:0]        host_wdata,
    input  logic                     blocked,
    input  logic [DATA_W-1:0]        cur_word,
    output logic [DATA_W-1:0]        host_rdata,
    output logic [$clog2(WORDS)-1:0] word_ptr,
    output logic                     store_we
);
    import tbuf_pkg::*;

    localparam int PTR_W    = $clog2(WORDS);
    localparam int DIR_BIT  = DATA_W - 1;
    localparam int AUTO_BIT = DATA_W - 2;

    host_mode_t        mode_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] rd_value;
    logic              ctrl_wr_ok;
    logic              data_wr_ok;
    logic              data_rd_ok;
    logic              data_hit;
    logic              unused_wbits;

    assign ctrl_wr_ok = !blocked && host_wr && (host_addr == HOST_REG_CTRL);
    assign data_wr_ok = !blocked && host_wr && (host_addr == HOST_REG_DATA) && mode_q.fill;
    assign data_rd_ok = !blocked && host_rd && (host_addr == HOST_REG_DATA) && !mode_q.fill;
    assign data_hit   = data_wr_ok || data_rd_ok;
    assign unused_wbits = ^host_wdata[AUTO_BIT-1:PTR_W];

    always_comb begin
        ctrl_view            = '0;
        ctrl_view[DIR_BIT]   = mode_q.fill;
        ctrl_view[AUTO_BIT]  = mode_q.auto_inc;
        ctrl_view[PTR_W-1:0] = ptr_q;
    end

    always_comb begin
        rd_value = '0;
        if (!blocked) begin
            if (host_addr == HOST_REG_CTRL) rd_value = ctrl_view;
            else if (data_rd_ok)            rd_value = cur_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ptr_q  <= '0;
        end else if (ctrl_wr_ok) begin
            mode_q.fill     <= host_wdata[DIR_BIT];
            mode_q.auto_inc <= host_wdata[AUTO_BIT];
            ptr_q           <= host_wdata[PTR_W-1:0];
        end else if (data_hit && mode_q.auto_inc) begin
            if (ptr_q == PTR_W'(WORDS - 1)) ptr_q <= '0;
            else                            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (host_rd) begin
            rdata_q <= rd_value;
        end
    end

    assign host_rdata = rdata_q;
    assign word_ptr   = ptr_q;
    assign store_we   = data_wr_ok;

endmodule

// File: rtl/tbuf_xfer_buffer.sv
module tbuf_xfer_buffer #(
    parameter int WORDS  = 128,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_addr,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    input  logic                     eng_start,
    input  logic [$clog2(WORDS)-1:0] eng_start_word,
    input  logic                     eng_done,
    input  logic                     eng_byte_wr,
    input  logic                     eng_byte_rd,
    input  logic [7:0]               eng_wdata,
    output logic [7:0]               eng_rdata,
    output logic                     eng_busy
);
    localparam int LANES   = DATA_W / tbuf_pkg::BYTE_W;
    localparam int WADDR_W = $clog2(WORDS);
    localparam int BIDX_W  = WADDR_W + $clog2(LANES);

    logic [WADDR_W-1:0] word_ptr;
    logic [BIDX_W-1:0]  byte_idx;
    logic [DATA_W-1:0]  cur_word;
    logic               host_store;
    logic               eng_wr_go;
    logic               host_blocked;

    // engine owns the buffer while active and in its start cycle
    assign host_blocked = eng_busy || eng_start;

    tbuf_seq #(.WORDS(WORDS), .LANES(LANES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_start  (eng_start),
        .start_word (eng_start_word),
        .eng_done   (eng_done),
        .byte_rd    (eng_byte_rd),
        .byte_wr    (eng_byte_wr),
        .busy       (eng_busy),
        .wr_go      (eng_wr_go),
        .byte_idx   (byte_idx)
    );

    tbuf_host_port #(.WORDS(WORDS), .DATA_W(DATA_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .blocked    (host_blocked),
        .cur_word   (cur_word),
        .host_rdata (host_rdata),
        .word_ptr   (word_ptr),
        .store_we   (host_store)
    );

    tbuf_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_store),
        .host_waddr (word_ptr),
        .host_wdata (host_wdata),
        .host_rword (cur_word),
        .eng_we     (eng_wr_go),
        .eng_idx    (byte_idx),
        .eng_wbyte  (eng_wdata),
        .eng_rbyte  (eng_rdata)
    );

endmodule

// File: rtl/tbuf_chk.sv
module tbuf_chk #(
    parameter int WORDS  = 128,
    parameter int DATA_W = 32
) (
    input logic                                            clk,
    input logic                                            rst_n,
    input logic                                            host_addr,
    input logic                                            host_wr,
    input logic                                            host_rd,
    input logic [DATA_W-1:0]                               host_rdata,
    input logic                                            eng_start,
    input logic [$clog2(WORDS)-1:0]                        eng_start_word,
    input logic                                            eng_done,
    input logic                                            eng_byte_wr,
    input logic                                            eng_byte_rd,
    input logic                                            eng_busy,
    input logic [$clog2(WORDS)-1:0]                        word_ptr,
    input logic [$clog2(WORDS)+$clog2(DATA_W/8)-1:0]       byte_idx
);
    localparam int LANE_W = $clog2(DATA_W / 8);

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> eng_busy); // R6

    AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && eng_done && !eng_start) |=> !eng_busy); // R6

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> (byte_idx[LANE_W-1:0] == '0) &&
                      (byte_idx[$bits(byte_idx)-1:LANE_W] == $past(eng_start_word))); // R7

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_start && (eng_byte_rd || eng_byte_wr))
        |=> byte_idx == $past(byte_idx) + 1'b1); // R7

    AST_IDX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy && !eng_start) |=> $stable(byte_idx)); // R7

    AST_BLOCKED_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (eng_busy || eng_start)) |=> host_rdata == '0); // R10

    AST_PTR_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy || eng_start) |=> $stable(word_ptr)); // R10

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == 1'b0)
        |=> (word_ptr == $past(word_ptr)) || (word_ptr == $past(word_ptr) + 1'b1)); // R5

endmodule

bind tbuf_xfer_buffer tbuf_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_addr      (host_addr),
    .host_wr        (host_wr),
    .host_rd        (host_rd),
    .host_rdata     (host_rdata),
    .eng_start      (eng_start),
    .eng_start_word (eng_start_word),
    .eng_done       (eng_done),
    .eng_byte_wr    (eng_byte_wr),
    .eng_byte_rd    (eng_byte_rd),
    .eng_busy       (eng_busy),
    .word_ptr       (word_ptr),
    .byte_idx       (byte_idx)
);

// File: tb/tb_tbuf_xfer_buffer.sv
module tb_tbuf_xfer_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_addr = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        eng_start = 1'b0;
    logic [6:0]  eng_start_word = '0;
    logic        eng_done = 1'b0;
    logic        eng_byte_wr = 1'b0;
    logic        eng_byte_rd = 1'b0;
    logic [7:0]  eng_wdata = '0;
    logic [7:0]  eng_rdata;
    logic        eng_busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // requirement model
    logic [31:0] mdl [128];
    logic        m_fill, m_auto, m_busy;
    logic [6:0]  m_ptr;
    logic [8:0]  m_idx;

    always #10 clk = ~clk;

    tbuf_xfer_buffer dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_start(eng_start), .eng_start_word(eng_start_word), .eng_done(eng_done),
        .eng_byte_wr(eng_byte_wr), .eng_byte_rd(eng_byte_rd), .eng_wdata(eng_wdata),
        .eng_rdata(eng_rdata), .eng_busy(eng_busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_exp();
        return {m_fill, m_auto, 22'd0, 1'b0, m_ptr};
    endfunction

    function automatic logic [7:0] byte_exp(input logic [8:0] i);
        return mdl[i[8:2]][i[1:0]*8 +: 8];
    endfunction

    task automatic adv_ptr();
        if (m_auto) m_ptr = m_ptr + 7'd1;
    endtask

    task automatic host_write(input logic a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        if (!m_busy) begin
            if (a == 1'b0) begin
                m_fill = d[31]; m_auto = d[30]; m_ptr = d[6:0];
            end else if (m_fill) begin
                mdl[m_ptr] = d; adv_ptr();
            end
        end
    endtask

    task automatic host_read(input logic a, input string req);
        logic [31:0] exp;
        host_addr = a; host_rd = 1'b1;
        if (m_busy)          exp = '0;
        else if (a == 1'b0)  exp = ctrl_exp();
        else if (!m_fill)    exp = mdl[m_ptr];
        else                 exp = '0;
        @(negedge clk);
        host_rd = 1'b0;
        if (!m_busy && a == 1'b1 && !m_fill) adv_ptr();
        chk(host_rdata === exp, req, host_rdata, exp);
    endtask

    task automatic eng_begin(input logic [6:0] w);
        eng_start = 1'b1; eng_start_word = w;
        @(negedge clk);
        eng_start = 1'b0;
        m_busy = 1'b1; m_idx = {w, 2'b00};
    endtask

    task automatic eng_end();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        m_busy = 1'b0;
    endtask

    task automatic eng_get(input string req);
        logic [7:0] e;
        e = m_busy ? byte_exp(m_idx) : 8'h00;
        if (m_busy) chk(eng_rdata === e, req, {24'd0, eng_rdata}, {24'd0, e});
        eng_byte_rd = 1'b1;
        @(negedge clk);
        eng_byte_rd = 1'b0;
        if (m_busy) m_idx = m_idx + 9'd1;
    endtask

    task automatic eng_put(input logic [7:0] b);
        eng_wdata = b; eng_byte_wr = 1'b1;
        @(negedge clk);
        eng_byte_wr = 1'b0;
        if (m_busy) begin
            mdl[m_idx[8:2]][m_idx[1:0]*8 +: 8] = b;
            m_idx = m_idx + 9'd1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int w = 0; w < 128; w++) mdl[w] = '0;
        m_fill = 0; m_auto = 0; m_busy = 0; m_ptr = '0; m_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(eng_busy === 1'b0, "R1 busy", {31'd0, eng_busy}, 32'd0);
        host_read(1'b0, "R1 ctrl");
        host_read(1'b1, "R1 data");

        // R2 control layout, pointer bit 7 dropped
        host_write(1'b0, 32'hFFFF_FFFF);
        host_read(1'b0, "R2 ctrl readback");

        // R5 pointer wrap 127 -> 0
        host_write(1'b1, 32'hA5A5_0001);
        host_read(1'b0, "R5 wrap");
        host_write(1'b1, 32'h0BAD_0000);

        // R3 read against fill direction: zero, pointer held
        host_read(1'b1, "R3 mismatch read");
        host_read(1'b0, "R3 ptr held");
        host_write(1'b0, 32'h4000_007F);
        host_read(1'b1, "R3 drain 127");
        host_read(1'b1, "R3 drain 0");
        host_write(1'b1, 32'hDEAD_BEEF);
        host_read(1'b0, "R3 write ignored in drain");

        // R4 auto-increment off
        host_write(1'b0, 32'h8000_0005);
        host_write(1'b1, 32'h1111_1111);
        host_write(1'b1, 32'h4433_2211);
        host_read(1'b0, "R4 ptr held");

        // R8 little-endian engine read, R6 busy
        eng_begin(7'd5);
        chk(eng_busy === 1'b1, "R6 busy set", {31'd0, eng_busy}, 32'd1);
        for (int k = 0; k < 4; k++) eng_get("R8 byte order");
        eng_end();
        chk(eng_busy === 1'b0, "R6 busy clear", {31'd0, eng_busy}, 32'd0);

        // R10 host blocked while active
        eng_begin(7'd5);
        host_read(1'b0, "R10 read zero");
        host_write(1'b0, 32'h0000_0000);
        host_write(1'b1, 32'hCAFE_CAFE);
        eng_end();
        host_read(1'b0, "R10 ctrl unchanged");

        // R7 idle byte strobes ignored
        eng_put(8'hEE);
        host_write(1'b0, 32'h0000_0005);
        host_read(1'b1, "R7 idle write ignored");

        // R7 index wraps 511 -> 0
        eng_begin(7'd127);
        for (int k = 0; k < 5; k++) eng_get("R7 index wrap");
        eng_end();

        // R9 partial final word keeps upper lane
        eng_begin(7'd5);
        eng_put(8'hAA); eng_put(8'hBB); eng_put(8'hCC);
        eng_end();
        host_write(1'b0, 32'h0000_0005);
        host_read(1'b1, "R9 partial word");

        // R6 restart while active
        eng_begin(7'd5);
        eng_get("R6 before restart");
        eng_begin(7'd6);
        eng_get("R6 restart index");
        eng_end();

        // R10 host write in the engine start cycle
        host_write(1'b0, 32'hC000_0009);
        eng_start = 1'b1; eng_start_word = 7'd0;
        host_addr = 1'b1; host_wdata = 32'h1234_5678; host_wr = 1'b1;
        @(negedge clk);
        eng_start = 1'b0; host_wr = 1'b0;
        m_busy = 1'b1; m_idx = '0;
        eng_end();
        host_read(1'b0, "R10 start-cycle ptr");
        host_write(1'b0, 32'h0000_0009);
        host_read(1'b1, "R10 start-cycle data");

        // random rounds: R3 R4 R8 R9
        for (int r = 0; r < 40; r++) begin
            logic [6:0] sw;
            int nb;
            sw = 7'($urandom % 128);
            nb = 1 + int'($urandom % 40);
            if (r % 2 == 0) begin
                host_write(1'b0, {2'b11, 23'd0, sw});
                for (int k = 0; k < (nb + 3) / 4; k++) host_write(1'b1, $urandom);
                eng_begin(sw);
                for (int k = 0; k < nb; k++) eng_get("R8 random drain");
                eng_end();
            end else begin
                eng_begin(sw);
                for (int k = 0; k < nb; k++) eng_put(8'($urandom));
                eng_end();
                host_write(1'b0, {2'b01, 23'd0, sw});
                for (int k = 0; k < (nb + 3) / 4; k++) host_read(1'b1, "R9 random fill");
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule